// File: doc/BRIEF.md
# Streaming CRC-32 Engine with Byte-Granular Beats

This block computes a 32-bit cyclic redundancy check over a packet that arrives as a stream of beats on a 64-bit data bus. Each beat carries between one and eight valid bytes. A per-beat count field sets how many, so the width can change on any beat and the last beat of a packet can carry a partial word. The remainder is seeded from a 32-bit initial value on the start-of-packet beat. The seed depends on the protocol, for example all zeros, all ones, or 0x52325032.

Data is folded in most-significant bit first within each byte. All the bytes of a beat are folded in a single cycle by an unrolled XOR network. The running remainder is visible on every cycle. When an end-of-packet beat completes, the final remainder is presented with a one-cycle valid pulse. No output inversion is applied.

In double-rate mode the engine takes one wide word every two internal cycles. It folds the word as two 32-bit halves, so the fabric side can run at half the internal rate. The engine accepts nothing until its enable input is high.

Top module: `crc32_stream`

## Requirements
- R1: After reset, `crc_run`, `crc_out` and `crc_valid` are all zero.
- R2: The remainder follows the generator polynomial 0x04C11DB7, folding each byte most-significant bit first. With seed 0xFFFFFFFF, the ASCII string "123456789" gives 0x0376E6E7.
- R3: In single-rate mode, `in_nbytes` holds the byte count minus one (0 means 1 byte, 7 means 8 bytes). The valid bytes start at bits 63:56 and run downward. Bytes below the counted ones have no effect on the result.
- R4: A beat accepted with `in_sop` high starts from `init_value` instead of the held remainder. That beat's data is folded in the same cycle.
- R5: When the last fold of an end-of-packet beat completes, `crc_valid` is high for exactly one cycle. During that cycle `crc_out` equals `crc_run`, which holds the uninverted final remainder.
- R6: While `enable` is low, `in_ready` is low and no beat is accepted.
- R7: In double-rate mode (`dbl_mode` high when the beat is accepted), `in_ready` is low in the cycle after acceptance while the second half is folded.
- R8: In double-rate mode, bits 31:0 are folded first and bits 63:32 second, each half most-significant byte first. The count spans both halves: up to four bytes come from the low half, and any remaining bytes come from the high half.
- R9: `crc_run` changes only in a cycle that folds data.
- R10: A beat is accepted in a cycle where `in_valid` and `in_ready` are both high at the rising clock edge. `crc_run` shows the updated remainder after that edge in single-rate mode, and one cycle later in double-rate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Engine enable; nothing is accepted while low |
| dbl_mode | input | 1 | Double-rate mode select, sampled when a beat is accepted |
| init_value | input | 32 | Seed loaded on a start-of-packet beat |
| in_valid | input | 1 | Beat present |
| in_sop | input | 1 | Beat is the first of a packet |
| in_eop | input | 1 | Beat is the last of a packet |
| in_nbytes | input | 3 | Valid byte count minus one |
| in_data | input | 64 | Beat data |
| in_ready | output | 1 | Engine can accept a beat this cycle |
| crc_run | output | 32 | Running remainder |
| crc_out | output | 32 | Final remainder of the last completed packet |
| crc_valid | output | 1 | One-cycle pulse marking a new `crc_out` |

## Verification
The assertions check the handshake-level rules on every cycle:
- `in_ready` is held low while disabled and in the cycle after a double-rate acceptance.
- The remainder does not move in a cycle that folds nothing.
- `crc_valid` appears only after a finishing fold, and `crc_out` then agrees with `crc_run`.

The arithmetic itself can only be shown by the bench scenarios:
- The polynomial, the bit order within each byte and the byte placement across halves.
- Seeding from `init_value` on a start-of-packet beat.
- Ignoring the bytes below the count.

These scenarios use random packet lengths, random per-beat widths, a mix of seeds and a known check string, all compared against a bit-serial model.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

    localparam int CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

    typedef logic [CRC_W-1:0] crc_t;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    // One byte, most-significant bit first, shifted through the divisor.
    function automatic crc_t crc_byte_step(input crc_t c_in, input logic [7:0] b);
        crc_t c;
        logic fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ b[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/crc32_fold_net.sv
module crc32_fold_net
    import crc32_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8,
    localparam int CNT_W  = $clog2(NBYTES + 1)
) (
    input  crc_t              crc_in,
    input  logic [DATA_W-1:0] data,
    input  logic [CNT_W-1:0]  cnt,
    output crc_t              crc_res
);

    crc_t stage [0:NBYTES];

    assign stage[0] = crc_in;

    // Byte k sits at the k-th position counted from the top of the word.
    for (genvar k = 0; k < NBYTES; k++) begin : g_stage
        assign stage[k+1] = crc_byte_step(stage[k], data[DATA_W-1-8*k -: 8]);
    end

    always_comb begin
        crc_res = stage[0];
        for (int k = 1; k <= NBYTES; k++) begin
            if (cnt == CNT_W'(k)) crc_res = stage[k];
        end
    end

endmodule

// File: rtl/crc32_lane_select.sv
module crc32_lane_select
    import crc32_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int CNT_W  = $clog2(NBYTES + 1)
) (
    input  phase_e            phase,
    input  logic              dbl_mode,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CNT_W-1:0]  in_cnt,
    input  logic [HALF_W-1:0] held_hi,
    input  logic [CNT_W-1:0]  held_cnt,
    output logic [DATA_W-1:0] op_data,
    output logic [CNT_W-1:0]  op_cnt
);

    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(NBYTES / 2);

    always_comb begin
        if (phase == PH_SECOND) begin
            op_data = {held_hi, {HALF_W{1'b0}}};
            op_cnt  = (held_cnt > HALF_CNT) ? (held_cnt - HALF_CNT) : '0;
        end else if (dbl_mode) begin
            op_data = {in_data[HALF_W-1:0], {HALF_W{1'b0}}};
            op_cnt  = (in_cnt > HALF_CNT) ? HALF_CNT : in_cnt;
        end else begin
            op_data = in_data;
            op_cnt  = in_cnt;
        end
    end

endmodule

// File: rtl/crc32_beat_ctrl.sv
module crc32_beat_ctrl
    import crc32_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int CNT_W  = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              dbl_mode,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [CNT_W-1:0]  in_cnt,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output phase_e            phase,
    output logic [HALF_W-1:0] held_hi,
    output logic [CNT_W-1:0]  held_cnt,
    output logic              step_en,
    output logic              step_init,
    output logic              step_last
);

    logic accept;
    logic held_eop;
    logic second_go;

    assign in_ready  = enable && (phase == PH_FIRST);
    assign accept    = in_valid && in_ready;
    assign second_go = (phase == PH_SECOND) && enable;

    assign step_en   = accept || second_go;
    assign step_init = accept && in_sop;
    assign step_last = (accept && !dbl_mode && in_eop) || (second_go && held_eop);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_FIRST;
            held_hi  <= '0;
            held_cnt <= '0;
            held_eop <= 1'b0;
        end else begin
            if (accept && dbl_mode) begin
                phase    <= PH_SECOND;
                held_hi  <= in_data[DATA_W-1:HALF_W];
                held_cnt <= in_cnt;
                held_eop <= in_eop;
            end else if (second_go) begin
                phase    <= PH_FIRST;
            end
        end
    end

endmodule

// File: rtl/crc32_stream.sv
module crc32_stream
    import crc32_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int CNT_W  = $clog2(NBYTES + 1),
    localparam int NB_W   = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              dbl_mode,
    input  logic [CRC_W-1:0]  init_value,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [NB_W-1:0]   in_nbytes,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic [CRC_W-1:0]  crc_run,
    output logic [CRC_W-1:0]  crc_out,
    output logic              crc_valid
);

    phase_e            phase;
    logic [HALF_W-1:0] held_hi;
    logic [CNT_W-1:0]  held_cnt;
    logic [CNT_W-1:0]  in_cnt;
    logic              step_en, step_init, step_last;
    logic [DATA_W-1:0] op_data;
    logic [CNT_W-1:0]  op_cnt;
    crc_t              crc_q, fold_base, fold_res;
    logic              busy_second;

    assign in_cnt      = CNT_W'(in_nbytes) + CNT_W'(1);
    assign busy_second = (phase == PH_SECOND);

    crc32_beat_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .dbl_mode  (dbl_mode),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_cnt    (in_cnt),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .phase     (phase),
        .held_hi   (held_hi),
        .held_cnt  (held_cnt),
        .step_en   (step_en),
        .step_init (step_init),
        .step_last (step_last)
    );

    crc32_lane_select #(.DATA_W(DATA_W)) u_lane (
        .phase    (phase),
        .dbl_mode (dbl_mode),
        .in_data  (in_data),
        .in_cnt   (in_cnt),
        .held_hi  (held_hi),
        .held_cnt (held_cnt),
        .op_data  (op_data),
        .op_cnt   (op_cnt)
    );

    assign fold_base = step_init ? init_value : crc_q;

    crc32_fold_net #(.DATA_W(DATA_W)) u_fold (
        .crc_in  (fold_base),
        .data    (op_data),
        .cnt     (op_cnt),
        .crc_res (fold_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q     <= '0;
            crc_out   <= '0;
            crc_valid <= 1'b0;
        end else begin
            crc_valid <= 1'b0;
            if (step_en) crc_q <= fold_res;
            if (step_last) begin
                crc_out   <= fold_res;
                crc_valid <= 1'b1;
            end
        end
    end

    assign crc_run = crc_q;

endmodule

// File: rtl/crc32_stream_chk.sv
module crc32_stream_chk (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        dbl_mode,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_eop,
    input logic        busy,
    input logic [31:0] crc_run,
    input logic [31:0] crc_out,
    input logic        crc_valid
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_ready_gated_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !in_ready);

    assert_double_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && dbl_mode) |=> !in_ready);

    assert_final_matches_run_R5: assert property (@(posedge clk) disable iff (rst)
        crc_valid |-> (crc_out == crc_run));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (!$past(in_valid && in_ready) && !$past(busy && enable)) |-> $stable(crc_run));

    assert_valid_source_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
        crc_valid |-> ($past(in_valid && in_ready && in_eop && !dbl_mode) || $past(busy && enable)));

endmodule

bind crc32_stream crc32_stream_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .dbl_mode  (dbl_mode),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eop    (in_eop),
    .busy      (busy_second),
    .crc_run   (crc_run),
    .crc_out   (crc_out),
    .crc_valid (crc_valid)
);

// File: tb/crc32_stream_bench.sv
module crc32_stream_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        dbl_mode = 1'b0;
    logic [31:0] init_value = '0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [2:0]  in_nbytes = '0;
    logic [63:0] in_data = '0;
    logic        in_ready;
    logic [31:0] crc_run;
    logic [31:0] crc_out;
    logic        crc_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2ns clk = ~clk;

    crc32_stream u_crc32_stream (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .dbl_mode   (dbl_mode),
        .init_value (init_value),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_nbytes  (in_nbytes),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .crc_run    (crc_run),
        .crc_out    (crc_out),
        .crc_valid  (crc_valid)
    );

    // Bit-serial reference: one bit at a time, MSB first, no reflection.
    function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[31] ^ b[i]) r = (r << 1) ^ 32'h04C11DB7;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Place bytes per the mode's layout; unused byte lanes get random filler.
    function automatic logic [63:0] pack_word(input logic [7:0] b[8], input int nb, input bit dbl);
        logic [63:0] w;
        w = {$urandom, $urandom};
        for (int j = 0; j < nb; j++) begin
            if (!dbl)        w[63-8*j -: 8] = b[j];
            else if (j < 4)  w[31-8*j -: 8] = b[j];
            else             w[63-8*(j-4) -: 8] = b[j];
        end
        return w;
    endfunction

    task automatic do_beat(input logic [63:0] w, input int nb, input bit sop, input bit eop,
                           input bit dbl, input logic [31:0] exp_run, input string req);
        @(negedge clk);
        dbl_mode  = dbl;
        in_valid  = 1'b1;
        in_sop    = sop;
        in_eop    = eop;
        in_nbytes = 3'(nb - 1);
        in_data   = w;
        check(in_ready == 1'b1, "R10", {63'd0, in_ready}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        if (dbl) begin
            check(in_ready == 1'b0, "R7", {63'd0, in_ready}, 64'd0);
            @(negedge clk);
        end
        check(crc_run == exp_run, req, {32'd0, crc_run}, {32'd0, exp_run});
        if (eop) begin
            check(crc_valid == 1'b1, "R5", {63'd0, crc_valid}, 64'd1);
            check(crc_out == exp_run, "R5", {32'd0, crc_out}, {32'd0, exp_run});
            @(negedge clk);
            check(crc_valid == 1'b0, "R5", {63'd0, crc_valid}, 64'd0);
        end
    endtask

    task automatic send_packet(input logic [7:0] pkt[$], input logic [31:0] seed,
                               input bit dbl, input bit random_widths, input string req);
        logic [31:0] exp;
        logic [7:0]  b[8];
        int pos;
        int nb;
        exp = seed;
        pos = 0;
        init_value = seed;
        while (pos < pkt.size()) begin
            nb = random_widths ? (1 + int'($urandom % 8)) : 8;
            if (nb > pkt.size() - pos) nb = pkt.size() - pos;
            for (int j = 0; j < 8; j++) b[j] = (j < nb) ? pkt[pos+j] : 8'h00;
            for (int j = 0; j < nb; j++) exp = ref_byte(exp, b[j]);
            do_beat(pack_word(b, nb, dbl), nb, pos == 0, pos + nb == pkt.size(), dbl, exp, req);
            pos += nb;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0]  pkt[$];
        logic [31:0] held;
        logic [31:0] seeds[4];
        int unsigned seed_set;
        seed_set = $urandom(32'd20240611);
        seeds[0] = 32'h00000000;
        seeds[1] = 32'hFFFFFFFF;
        seeds[2] = 32'h52325032;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state; R6 disabled by default
        check(crc_run == 32'd0, "R1", {32'd0, crc_run}, 64'd0);
        check(crc_out == 32'd0, "R1", {32'd0, crc_out}, 64'd0);
        check(crc_valid == 1'b0, "R1", {63'd0, crc_valid}, 64'd0);
        check(in_ready == 1'b0, "R6", {63'd0, in_ready}, 64'd0);

        enable = 1'b1;

        // R2 known check string, full 8-byte beats then a 1-byte tail
        pkt = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        send_packet(pkt, 32'hFFFFFFFF, 1'b0, 1'b0, "R2");
        check(crc_out == 32'h0376E6E7, "R2", {32'd0, crc_out}, 64'h0376E6E7);
        // R8 same string in double-rate mode gives the same result
        send_packet(pkt, 32'hFFFFFFFF, 1'b1, 1'b0, "R8");
        check(crc_out == 32'h0376E6E7, "R8", {32'd0, crc_out}, 64'h0376E6E7);

        // R6 beats offered while disabled are not taken and leave the remainder alone
        held = crc_run;
        enable = 1'b0;
        @(negedge clk);
        in_valid = 1'b1;
        in_sop = 1'b1;
        in_data = {$urandom, $urandom};
        repeat (3) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R6", {63'd0, in_ready}, 64'd0);
            check(crc_run == held, "R6", {32'd0, crc_run}, {32'd0, held});
        end
        in_valid = 1'b0;
        in_sop = 1'b0;
        enable = 1'b1;
        // R9 idle cycles keep the remainder
        repeat (2) @(negedge clk);
        check(crc_run == held, "R9", {32'd0, crc_run}, {32'd0, held});

        // R4 single-byte packet loads the seed and folds in the same beat
        pkt = {8'hA5};
        send_packet(pkt, 32'h52325032, 1'b0, 1'b1, "R4");

        // R3 / R8 random packets, random per-beat widths, filler in unused lanes
        for (int p = 0; p < 90; p++) begin
            int len;
            bit dbl;
            string tag;
            seeds[3] = $urandom;
            len = 1 + int'($urandom % 40);
            dbl = (p % 3) == 1;
            tag = dbl ? "R8" : "R3";
            pkt.delete();
            for (int i = 0; i < len; i++) pkt.push_back(8'($urandom));
            send_packet(pkt, seeds[p % 4], dbl, 1'b1, tag);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule